// File: doc/BRIEF.md
# Trip Order Recorder

This block watches up to eight trip contacts and records the order in which they first close. Each contact comes in asynchronously. It is synchronized to the system clock, and only a rising edge counts as a trip. A shared sequence counter starts at 1. When a channel trips for the first time, the channel keeps the counter value it had at that moment as its order number, and the counter advances. A channel that has tripped holds its number. Later changes on its contact do not affect it until the recorder is cleared.

Each channel drives three outputs. The first is a 4-bit order number. While the channel has not tripped, this number follows the live counter, and it freezes once the channel trips. The second is a display enable that turns on after the trip. The third is a ready lamp that stays lit until the trip. A shared alarm sounds while any channel has tripped. In quiz mode the alarm is cut to a fixed number of cycles after the most recent new trip, so each answering team gets a short beep. A manual clear empties every channel and sets the counter back to 1.

Top module: `trip_order_recorder`

## Requirements
- R1: A channel latches on its first rising trip. Later falls and rises of its input change none of its outputs until a clear.
- R2: A clear, either manual_clr high at a clock edge or rst_n low, empties every channel and sets the sequence counter to ORDER_START (1).
- R3: A newly tripped channel keeps the counter value current in that cycle, and the counter then increases by one.
- R4: A tripped channel's order number stays frozen. An untripped channel's order number shows the live counter. Channel i's number occupies order_num bits [4i+3:4i], unsigned binary.
- R5: disp_en[i] is 0 until channel i has tripped and 1 afterwards.
- R6: ready[i] is 1 while channel i has not tripped and 0 once it has.
- R7: With quiz_mode low, alarm is the OR of all tripped channels.
- R8: With quiz_mode high, alarm is high for exactly ALARM_HOLD cycles after the cycle in which a new trip is recorded. Each further new trip restarts that interval.
- R9: Channels that trip in the same cycle get consecutive numbers, with the lowest channel index getting the smallest number.
- R10: The counter saturates at ORDER_MAX. Every channel that trips after saturation gets ORDER_MAX.
- R11: A trip becomes visible on the outputs after the third rising clock edge that follows the input change (two synchronizer flops plus the latch). An input still held high across a clear does not trip again until it falls and rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| manual_clr | input | 1 | Synchronous clear of all channels and the counter |
| quiz_mode | input | 1 | 1 limits the alarm to ALARM_HOLD cycles per new trip |
| trip_in | input | CHANNELS | Asynchronous trip contacts, active high |
| order_num | output | CHANNELS*ORDER_W | Order number per channel, 4 bits each |
| disp_en | output | CHANNELS | Display enable per channel |
| ready | output | CHANNELS | Ready lamp per channel |
| alarm | output | 1 | Audible alarm |

## Verification
The bench trips channels out of index order and checks each frozen number. A design that copied the counter continuously would show the same number on every channel. Three channels rising in one cycle must receive ascending numbers, and a design that counted one step per cycle instead of one per trip would hand them duplicates. The bench re-toggles a tripped input and holds inputs high across a clear, which exposes edge logic that re-arms on a level. In quiz mode, a second trip partway through the alarm interval must push the silence back, and a separate instance with a small ORDER_MAX must stop at its ceiling instead of wrapping.

// File: rtl/trip_order_recorder.sv
module trip_order_recorder #(
  parameter int CHANNELS    = 8,
  parameter int ORDER_W     = 4,
  parameter int ORDER_START = 1,
  parameter int ORDER_MAX   = 9,
  parameter int ALARM_HOLD  = 50_000_000,
  localparam int HOLD_W     = $clog2(ALARM_HOLD + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          manual_clr,
  input  logic                          quiz_mode,
  input  logic [CHANNELS-1:0]           trip_in,
  output logic [CHANNELS*ORDER_W-1:0]   order_num,
  output logic [CHANNELS-1:0]           disp_en,
  output logic [CHANNELS-1:0]           ready,
  output logic                          alarm
);

  logic [CHANNELS-1:0] sync_a, sync_b, sync_prev, tripped, fresh;
  logic [ORDER_W-1:0]  counter, counter_nxt;
  logic [ORDER_W-1:0]  stored [CHANNELS];
  logic [ORDER_W-1:0]  slot   [CHANNELS];
  logic [HOLD_W-1:0]   hold_cnt;

  assign fresh = sync_b & ~sync_prev & ~tripped;

  always_comb begin
    logic [ORDER_W-1:0] run;
    run = counter;
    for (int i = 0; i < CHANNELS; i++) begin
      slot[i] = run;
      if (fresh[i] && run < ORDER_W'(ORDER_MAX)) run = run + 1'b1;
    end
    counter_nxt = run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a    <= '0;
      sync_b    <= '0;
      sync_prev <= '0;
      tripped   <= '0;
      counter   <= ORDER_W'(ORDER_START);
      hold_cnt  <= '0;
      for (int i = 0; i < CHANNELS; i++) stored[i] <= '0;
    end else begin
      sync_a    <= trip_in;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
      if (manual_clr) begin
        tripped  <= '0;
        counter  <= ORDER_W'(ORDER_START);
        hold_cnt <= '0;
      end else begin
        tripped <= tripped | fresh;
        counter <= counter_nxt;
        for (int i = 0; i < CHANNELS; i++)
          if (fresh[i]) stored[i] <= slot[i];
        if (|fresh)            hold_cnt <= HOLD_W'(ALARM_HOLD);
        else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    assign order_num[g*ORDER_W +: ORDER_W] = tripped[g] ? stored[g] : counter;

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      tripped[g] |=> $stable(stored[g])); // R4
  end

  assign disp_en = tripped;
  assign ready   = ~tripped;
  assign alarm   = (|tripped) & (~quiz_mode | (hold_cnt != '0));

  AST_LATCH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !manual_clr |=> ((tripped & $past(tripped)) == $past(tripped))); // R1

  AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    manual_clr |=> (tripped == '0 && counter == ORDER_W'(ORDER_START))); // R2

  AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ORDER_START + $countones(tripped) >= ORDER_MAX)
      ? (counter == ORDER_W'(ORDER_MAX))
      : (int'(counter) == ORDER_START + $countones(tripped))); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    counter <= ORDER_W'(ORDER_MAX)); // R10

  AST_SILENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped == '0) |-> !alarm); // R7

endmodule

// File: tb/tb_trip_order_recorder.sv
module tb_trip_order_recorder;
  localparam int CH = 8;
  localparam int HOLD = 20;

  logic clk = 0, rst_n = 0, manual_clr = 0, quiz_mode = 0;
  logic [CH-1:0] trip_in = '0, trip_sat = '0;
  logic [CH*4-1:0] order_num, order_sat;
  logic [CH-1:0] disp_en, ready, disp_sat, ready_sat;
  logic alarm, alarm_sat;
  int compared = 0, mismatched = 0;

  always #10 clk = ~clk;

  trip_order_recorder #(.ALARM_HOLD(HOLD)) dut (
    .clk, .rst_n, .manual_clr, .quiz_mode, .trip_in,
    .order_num, .disp_en, .ready, .alarm);

  trip_order_recorder #(.ALARM_HOLD(HOLD), .ORDER_MAX(3)) dut_sat (
    .clk, .rst_n, .manual_clr(1'b0), .quiz_mode(1'b0), .trip_in(trip_sat),
    .order_num(order_sat), .disp_en(disp_sat), .ready(ready_sat), .alarm(alarm_sat));

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ord(int i);
    return int'(order_num[i*4 +: 4]);
  endfunction

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R5 disp after reset", disp_en, 0);
    chk("R6 ready after reset", ready, 8'hFF);
    chk("R7 alarm after reset", alarm, 0);
    for (int i = 0; i < CH; i++) chk("R2 order shows 1", ord(i), 1);
  endtask

  task automatic t_sequence();
    trip_in[4] = 1;
    edges(2);
    chk("R11 not yet at 2 edges", disp_en[4], 0);
    edges(1);
    chk("R11 visible at 3 edges", disp_en[4], 1);
    chk("R3 first trip number", ord(4), 1);
    chk("R7 alarm on", alarm, 1);
    trip_in[7] = 1; edges(3);
    trip_in[0] = 1; edges(3);
    chk("R3 ch7 number", ord(7), 2);
    chk("R3 ch0 number", ord(0), 3);
    chk("R4 ch4 frozen", ord(4), 1);
    chk("R4 untripped follows counter", ord(1), 4);
    chk("R6 ready pattern", ready, 8'b0110_1110);
    chk("R5 disp pattern", disp_en, 8'b1001_0001);
  endtask

  task automatic t_ignore();
    trip_in[4] = 0; edges(3);
    trip_in[4] = 1; edges(4);
    chk("R1 retoggle keeps number", ord(4), 1);
    chk("R1 counter unchanged", ord(1), 4);
    chk("R1 disp kept", disp_en[4], 1);
  endtask

  task automatic t_simultaneous();
    trip_in[6] = 1; trip_in[2] = 1; trip_in[3] = 1;
    edges(3);
    chk("R9 ch2 lowest", ord(2), 4);
    chk("R9 ch3 next", ord(3), 5);
    chk("R9 ch6 last", ord(6), 6);
    chk("R3 counter after burst", ord(1), 7);
    trip_in[1] = 1; trip_in[5] = 1; edges(3);
    chk("R9 ch1", ord(1), 7);
    chk("R9 ch5", ord(5), 8);
    chk("R6 all tripped", ready, 0);
  endtask

  task automatic t_clear();
    manual_clr = 1; edges(1);
    manual_clr = 0; edges(4);
    chk("R2 disp cleared", disp_en, 0);
    chk("R2 ready restored", ready, 8'hFF);
    chk("R2 alarm off", alarm, 0);
    chk("R2 counter preset", ord(5), 1);
    chk("R11 held inputs do not retrip", disp_en, 0);
    trip_in = '0; edges(4);
  endtask

  task automatic t_quiz();
    quiz_mode = 1;
    trip_in[3] = 1; edges(3);
    chk("R8 alarm starts", alarm, 1);
    chk("R3 number after clear", ord(3), 1);
    edges(HOLD - 1);
    chk("R8 alarm last cycle", alarm, 1);
    edges(1);
    chk("R8 alarm expires", alarm, 0);
    chk("R1 channel still tripped", disp_en[3], 1);
    manual_clr = 1; edges(1); manual_clr = 0;
    trip_in = '0; edges(4);
    trip_in[3] = 1; edges(3);
    edges(10);
    trip_in[6] = 1; edges(12);
    chk("R8 restart extends alarm", alarm, 1);
    edges(10);
    chk("R8 restarted last cycle", alarm, 1);
    edges(1);
    chk("R8 restarted expiry", alarm, 0);
    quiz_mode = 0; edges(1);
    chk("R7 normal mode alarm back", alarm, 1);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 5; i++) begin
      trip_sat[i] = 1; edges(3);
    end
    chk("R10 ch0", int'(order_sat[3:0]), 1);
    chk("R10 ch2 at max", int'(order_sat[11:8]), 3);
    chk("R10 ch3 held at max", int'(order_sat[15:12]), 3);
    chk("R10 ch4 held at max", int'(order_sat[19:16]), 3);
    chk("R10 untripped shows max", int'(order_sat[23:20]), 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    edges(1);
    t_reset();
    t_sequence();
    t_ignore();
    t_simultaneous();
    t_clear();
    t_quiz();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule